// File: doc/BRIEF.md
# Vector Merge and Move Execution Unit

This unit carries out the integer merge and move instruction group of a small vector datapath. At a start pulse it takes a 32-bit instruction word, a scalar operand, the active vector length, the element-width code and three source vectors: the mask vector and the two data operands. It then writes the destination vector back one element per clock on a narrow write port, with the index of each element.

One datapath serves both kinds of operation. A move copies the vector operand, or broadcasts the scalar or the immediate, into every active element. A merge picks, element by element, between the second vector operand and the first operand, as the mask bit for that element decides. In the same pass, every element past the active length is written as zero. An instruction outside the group, or a malformed one, produces a one-cycle illegal pulse and writes nothing.

Top module: `vmm_unit`

## Requirements
- R1: A word is in the group when bits 6:0 are 1010111 and bits 31:26 are 010111. Bit 25 set selects move and bit 25 clear selects merge. Bits 14:12 select the operand: 000 is the first vector operand, 100 is the scalar, and 011 is the immediate. The destination register number (bits 11:7) appears on `wr_vd` during the writes.
- R2: A word outside the group, a value of bits 14:12 other than the three listed, or a move with bits 24:20 not zero, raises `illegal` for exactly the one cycle after start. In that case `wr_en` and `done` stay low.
- R3: In a merge, active element i takes the element of `vs2_data` when bit i of `mask_vec` is 0. When the bit is 1 it takes the selected operand.
- R4: In a move, every active element takes the selected operand, whatever `mask_vec` holds.
- R5: Width codes 0, 1, 2 and 3 select elements of 8, 16, 32 and 64 bits. Element i of a source vector occupies bits [i*EW +: EW]. The scalar is cut to its low EW bits, and `wr_data` carries the element zero-extended to 64 bits.
- R6: The immediate is bits 19:15 read as a signed 5-bit value, sign-extended and then cut to the element width.
- R7: Elements with index from the active length up to VLEN/EW-1 are written as zero.
- R8: An active length of 0 writes nothing, and `done` rises in the cycle after start.
- R9: An active length above VLEN/EW is treated as VLEN/EW.
- R10: Writes begin in the cycle after start. There is one write per cycle, with `wr_idx` going 0,1,…,VLEN/EW-1. `busy` is high during the writes. `done` is high for the single cycle after the last write. A start pulse while the unit is occupied is ignored.
- R11: After reset, `busy`, `done`, `illegal` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accepts an instruction when the unit is idle |
| instr | input | 32 | Instruction word |
| scalar | input | ELEN | Scalar operand |
| vl | input | VL_W | Requested active length in elements |
| sew | input | 2 | Element-width code |
| mask_vec | input | VLEN | Mask vector; bit i governs element i |
| vs1_data | input | VLEN | First vector operand |
| vs2_data | input | VLEN | Second vector operand (merge fallback) |
| busy | output | 1 | Element writes in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| wr_en | output | 1 | Destination element write strobe |
| wr_vd | output | 5 | Destination register number |
| wr_idx | output | IDX_W | Index of the element being written |
| wr_data | output | ELEN | Element value, zero-extended |

## Verification
The checker watches the handshake on every cycle. It checks that writes, done and illegal never overlap, that indices start at zero and rise by one, that done follows the last write, and that done and illegal last one cycle each. The values are another matter: mask selection, truncation, immediate sign extension, tail zeroing, length clamping and the zero-length case can only be seen in the bench's scenarios. There the scoreboard compares every written element against a value worked out from the operands.

// File: rtl/vmm_pkg.sv
// Shared constants and types for the vector merge/move unit.
// Assumes instruction fields sit at the standard 32-bit vector positions.
package vmm_pkg;
    localparam logic [6:0] OPC_VEC   = 7'b1010111;
    localparam logic [5:0] F6_MRGMV  = 6'b010111;
    localparam logic [2:0] F3_VV     = 3'b000;
    localparam logic [2:0] F3_VX     = 3'b100;
    localparam logic [2:0] F3_VI     = 3'b011;

    typedef enum logic [1:0] {SRC_VEC, SRC_SCALAR, SRC_IMM} src_e;

    typedef struct packed {
        logic       legal;
        logic       merge;
        src_e       src;
        logic [4:0] vd;
        logic [4:0] imm;
    } dec_t;
endpackage

// File: rtl/vmm_decode.sv
// Combinational decoder for the merge/move group.
// Flags words outside the group, reserved operand forms and moves with vs2 != 0.
module vmm_decode
    import vmm_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);
    // Field extraction and legality check.
    always_comb begin
        logic in_grp;
        logic f3_ok;
        in_grp    = (instr[6:0] == OPC_VEC) && (instr[31:26] == F6_MRGMV);
        f3_ok     = (instr[14:12] == F3_VV) || (instr[14:12] == F3_VX) ||
                    (instr[14:12] == F3_VI);
        dec.merge = ~instr[25];
        dec.vd    = instr[11:7];
        dec.imm   = instr[19:15];
        case (instr[14:12])
            F3_VX:   dec.src = SRC_SCALAR;
            F3_VI:   dec.src = SRC_IMM;
            default: dec.src = SRC_VEC;
        endcase
        dec.legal = in_grp && f3_ok && !(instr[25] && (instr[24:20] != 5'd0));
    end
endmodule

// File: rtl/vmm_elem_sel.sv
// Per-element datapath: extracts element idx at width sew, applies the mask
// choice for merges, truncates the scalar and zeroes tail elements.
// Assumes VLEN >= ELEN and the scalar is already sign-resolved to ELEN bits.
module vmm_elem_sel #(
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int IDX_W = 4,
    parameter int VL_W  = 5
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [1:0]       sew,
    input  logic [VL_W-1:0]  vl_eff,
    input  logic             merge,
    input  logic             use_scal,
    input  logic [ELEN-1:0]  scal,
    input  logic [VLEN-1:0]  mask_vec,
    input  logic [VLEN-1:0]  vs1,
    input  logic [VLEN-1:0]  vs2,
    output logic [ELEN-1:0]  data
);
    localparam int SH_W = $clog2(VLEN);

    logic [SH_W-1:0] sh;
    logic [ELEN-1:0] wmask;
    logic [VLEN-1:0] s1_sh, s2_sh;
    logic [ELEN-1:0] opnd, e2;

    // Bit offset of the element and the width mask.
    always_comb begin
        sh = SH_W'(idx) << (3 + sew);
        case (sew)
            2'd0:    wmask = ELEN'({8{1'b1}});
            2'd1:    wmask = ELEN'({16{1'b1}});
            2'd2:    wmask = ELEN'({32{1'b1}});
            default: wmask = '1;
        endcase
    end

    // Operand selection, mask choice and tail zeroing.
    always_comb begin
        s1_sh = vs1 >> sh;
        s2_sh = vs2 >> sh;
        e2    = s2_sh[ELEN-1:0] & wmask;
        opnd  = (use_scal ? scal : s1_sh[ELEN-1:0]) & wmask;
        if (VL_W'(idx) >= vl_eff)
            data = '0;
        else if (merge && !mask_vec[idx])
            data = e2;
        else
            data = opnd;
    end
endmodule

// File: rtl/vmm_seq.sv
// Sequencer: accepts an instruction when idle, steps the element index once
// per cycle up to last_idx, then pulses done; illegal words pulse illegal.
module vmm_seq #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             legal,
    input  logic             len_zero,
    input  logic [IDX_W-1:0] last_idx,
    output logic             accept,
    output logic             running,
    output logic [IDX_W-1:0] idx,
    output logic             done,
    output logic             illegal
);
    typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN, S_BAD} st_e;
    st_e st;

    assign accept  = start && (st == S_IDLE);
    assign running = (st == S_RUN);
    assign done    = (st == S_FIN);
    assign illegal = (st == S_BAD);

    // State and element index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= S_IDLE;
            idx <= '0;
        end else begin
            case (st)
                S_IDLE: if (accept) begin
                    idx <= '0;
                    if (!legal)        st <= S_BAD;
                    else if (len_zero) st <= S_FIN;
                    else               st <= S_RUN;
                end
                S_RUN: if (idx == last_idx) st <= S_FIN;
                       else                 idx <= idx + 1'b1;
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vmm_unit.sv
// Top of the vector merge/move unit: decodes, captures operands on accept and
// streams the destination elements (active, then zeroed tail) one per cycle.
// Assumes VLEN is a power of two, at least ELEN, and ELEN = 64.
module vmm_unit #(
    parameter int VLEN  = 128,
    parameter int ELEN  = 64,
    parameter int IDX_W = $clog2(VLEN / 8),
    parameter int VL_W  = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [31:0]      instr,
    input  logic [ELEN-1:0]  scalar,
    input  logic [VL_W-1:0]  vl,
    input  logic [1:0]       sew,
    input  logic [VLEN-1:0]  mask_vec,
    input  logic [VLEN-1:0]  vs1_data,
    input  logic [VLEN-1:0]  vs2_data,
    output logic             busy,
    output logic             done,
    output logic             illegal,
    output logic             wr_en,
    output logic [4:0]       wr_vd,
    output logic [IDX_W-1:0] wr_idx,
    output logic [ELEN-1:0]  wr_data
);
    import vmm_pkg::*;

    dec_t            dec;
    logic            accept, running;
    logic [VL_W-1:0] nelem_in, vl_clamp, r_nelem, r_vl;
    logic [ELEN-1:0] scal_in, r_scal;
    logic [VLEN-1:0] r_mask, r_vs1, r_vs2;
    logic [1:0]      r_sew;
    logic            r_merge, r_use_scal;
    logic [IDX_W-1:0] idx;

    vmm_decode u_dec (.instr(instr), .dec(dec));

    // Element count, length clamp and scalar/immediate resolution.
    always_comb begin
        nelem_in = VL_W'(VLEN / 8) >> sew;
        vl_clamp = (vl > nelem_in) ? nelem_in : vl;
        scal_in  = (dec.src == SRC_IMM) ? {{(ELEN-5){dec.imm[4]}}, dec.imm} : scalar;
    end

    // Operand capture at instruction accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_mask <= '0; r_vs1 <= '0; r_vs2 <= '0; r_scal <= '0;
            r_sew <= '0; r_vl <= '0; r_nelem <= '0;
            r_merge <= 1'b0; r_use_scal <= 1'b0; wr_vd <= '0;
        end else if (accept) begin
            r_mask     <= mask_vec;
            r_vs1      <= vs1_data;
            r_vs2      <= vs2_data;
            r_scal     <= scal_in;
            r_sew      <= sew;
            r_vl       <= vl_clamp;
            r_nelem    <= nelem_in;
            r_merge    <= dec.merge;
            r_use_scal <= (dec.src != SRC_VEC);
            wr_vd      <= dec.vd;
        end
    end

    vmm_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(dec.legal),
        .len_zero(vl_clamp == '0), .last_idx(IDX_W'(r_nelem - 1'b1)),
        .accept(accept), .running(running), .idx(idx),
        .done(done), .illegal(illegal)
    );

    vmm_elem_sel #(.VLEN(VLEN), .ELEN(ELEN), .IDX_W(IDX_W), .VL_W(VL_W)) u_sel (
        .idx(idx), .sew(r_sew), .vl_eff(r_vl), .merge(r_merge),
        .use_scal(r_use_scal), .scal(r_scal), .mask_vec(r_mask),
        .vs1(r_vs1), .vs2(r_vs2), .data(wr_data)
    );

    assign busy   = running;
    assign wr_en  = running;
    assign wr_idx = idx;
endmodule

// File: rtl/vmm_unit_chk.sv
// Protocol checker for vmm_unit, attached by bind.
module vmm_unit_chk #(
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic             illegal,
    input logic             wr_en,
    input logic [IDX_W-1:0] wr_idx
);
    assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en, done, illegal}));
    assert_first_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_en) |-> wr_idx == '0);
    assert_idx_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> wr_idx == IDX_W'($past(wr_idx) + 1'b1));
    assert_done_after_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_en) |-> done);
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_ill_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> (!illegal && !wr_en));
    assert_ill_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> $past(start));
endmodule

bind vmm_unit vmm_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .illegal(illegal), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/vmm_unit_tb_top.sv
`timescale 1ns/1ps
module vmm_unit_tb_top;
    localparam int VLEN = 128, ELEN = 64, IDX_W = 4, VL_W = 5;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [31:0] instr = '0;
    logic [ELEN-1:0] scalar = '0;
    logic [VL_W-1:0] vl = '0;
    logic [1:0] sew = '0;
    logic [VLEN-1:0] mask_vec = '0, vs1_data = '0, vs2_data = '0;
    logic busy, done, illegal, wr_en;
    logic [4:0] wr_vd;
    logic [IDX_W-1:0] wr_idx;
    logic [ELEN-1:0] wr_data;

    int n_chk = 0, n_fail = 0;
    int q_idx[$];
    logic [63:0] q_dat[$];
    string cur_tag = "";
    bit done_seen, ill_seen;
    int writes_seen;
    logic [4:0] exp_vd;

    always #5 clk = ~clk;

    vmm_unit dut_i (.*);

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input bit vm, input logic [4:0] v2, input logic [4:0] r1,
                                         input logic [2:0] f3, input logic [4:0] vd);
        return {6'b010111, vm, v2, r1, f3, vd, 7'b1010111};
    endfunction

    function automatic logic [63:0] elem(input logic [127:0] v, input int i, input int ew);
        logic [63:0] r = '0;
        for (int b = 0; b < ew; b++) r[b] = v[i*ew + b];
        return r;
    endfunction

    // Monitor: pops the scoreboard on each write, records completion pulses.
    always @(negedge clk) begin
        if (rst_n && wr_en) begin
            writes_seen++;
            if (q_idx.size() == 0) begin
                check(0, {cur_tag, " unexpected write"}, {60'd0, wr_idx}, 64'd0);
            end else begin
                int ei;
                logic [63:0] ed;
                ei = q_idx.pop_front();
                ed = q_dat.pop_front();
                check(wr_idx == IDX_W'(ei), {cur_tag, " R10 index"}, {60'd0, wr_idx}, 64'(ei));
                check(wr_data == ed, {cur_tag, " data"}, wr_data, ed);
                check(wr_vd == exp_vd, {cur_tag, " R1 vd"}, {59'd0, wr_vd}, {59'd0, exp_vd});
                check(busy, {cur_tag, " R10 busy"}, {63'd0, busy}, 64'd1);
            end
        end
        if (rst_n && done) done_seen = 1;
        if (rst_n && illegal) ill_seen = 1;
    end

    // Driver: computes the expected elements, pushes them, issues the word.
    task automatic run_op(input logic [31:0] ins, input logic [63:0] sc, input int vlv, input int sw,
                          input logic [127:0] m, input logic [127:0] a, input logic [127:0] b,
                          input bit exp_ill, input bit poke_busy, input string tag);
        int ew = 8 << sw;
        int ne = VLEN / ew;
        int ve = (vlv > ne) ? ne : vlv;
        logic [63:0] wm = (ew == 64) ? '1 : ((64'd1 << ew) - 1);
        logic [63:0] op_s;
        bit mrg = !ins[25];
        cur_tag = tag;
        exp_vd = ins[11:7];
        op_s = (ins[14:12] == 3'b011) ? ({{59{ins[19]}}, ins[19:15]} & wm) : (sc & wm);
        if (!exp_ill && ve > 0) begin
            for (int i = 0; i < ne; i++) begin
                logic [63:0] v;
                if (i >= ve) v = '0;
                else if (mrg && !m[i]) v = elem(b, i, ew);
                else if (ins[14:12] == 3'b000) v = elem(a, i, ew);
                else v = op_s;
                q_idx.push_back(i);
                q_dat.push_back(v);
            end
        end
        done_seen = 0; ill_seen = 0; writes_seen = 0;
        @(negedge clk);
        instr = ins; scalar = sc; vl = VL_W'(vlv); sew = 2'(sw);
        mask_vec = m; vs1_data = a; vs2_data = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            instr = 32'hFFFF_FFFF; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        for (int t = 0; t < 40 && !done_seen && !ill_seen; t++) @(negedge clk);
        repeat (2) @(negedge clk);
        check(ill_seen == exp_ill, {tag, " R2 illegal"}, {63'd0, ill_seen}, {63'd0, exp_ill});
        check(done_seen == !exp_ill, {tag, " R10 done"}, {63'd0, done_seen}, {63'd0, !exp_ill});
        check(q_idx.size() == 0, {tag, " missing writes"}, 64'(q_idx.size()), 64'd0);
        q_idx.delete(); q_dat.delete();
    endtask

    initial begin
        #2_000_000;
        check(0, "watchdog", 64'd0, 64'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [127:0] A = 128'h0F1E2D3C_4B5A6978_8796A5B4_C3D2E1F0;
        logic [127:0] B = 128'h11223344_55667788_99AABBCC_DDEEFF00;
        repeat (3) @(negedge clk);
        // R11: reset state
        check(!busy && !done && !illegal && !wr_en, "R11 reset outputs",
              {60'd0, busy, done, illegal, wr_en}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3 R1: merge vector-vector, 8-bit, full length
        run_op(enc(0, 5'd2, 5'd1, 3'b000, 5'd3), 64'd0, 16, 0, 128'hA5C3, A, B, 0, 0, "R3 merge vv sew8");
        // R5 R7 R3: merge scalar, 16-bit, tail from 5, scalar truncated
        run_op(enc(0, 5'd2, 5'd1, 3'b100, 5'd4), 64'hDEAD_BEEF_CAFE_1234, 5, 1, 128'h15, A, B, 0, 0, "R5 R7 merge vx sew16");
        // R6 R4: move immediate -3, 32-bit
        run_op(enc(1, 5'd0, 5'b11101, 3'b011, 5'd5), 64'd0, 4, 2, 128'h0, A, B, 0, 0, "R6 R4 move vi sew32");
        // R4 R7: move vector, 64-bit, vl 1, mask ignored
        run_op(enc(1, 5'd0, 5'd1, 3'b000, 5'd6), 64'd0, 1, 3, '1, A, B, 0, 0, "R4 R7 move vv sew64");
        // R6 R3: merge immediate +7, 64-bit
        run_op(enc(0, 5'd2, 5'd7, 3'b011, 5'd7), 64'd0, 2, 3, 128'h2, A, B, 0, 0, "R6 R3 merge vi sew64");
        // R4: move scalar with mask pattern present
        run_op(enc(1, 5'd0, 5'd9, 3'b100, 5'd8), 64'h0123_4567_89AB_CDEF, 11, 0, 128'h5A5A, A, B, 0, 0, "R4 move vx sew8");
        // R8: zero length
        run_op(enc(0, 5'd2, 5'd1, 3'b000, 5'd9), 64'd0, 0, 0, 128'h1, A, B, 0, 0, "R8 zero length");
        check(writes_seen == 0, "R8 no writes", 64'(writes_seen), 64'd0);
        // R9: length clamp
        run_op(enc(0, 5'd2, 5'd1, 3'b000, 5'd10), 64'd0, 31, 2, 128'h9, A, B, 0, 0, "R9 clamp sew32");
        check(writes_seen == 4, "R9 write count", 64'(writes_seen), 64'd4);
        // R2: illegal forms
        run_op({enc(1, 5'd0, 5'd1, 3'b000, 5'd1)} ^ 32'h1, 64'd0, 4, 0, 0, A, B, 1, 0, "R2 bad opcode");
        run_op(enc(1, 5'd0, 5'd1, 3'b001, 5'd1), 64'd0, 4, 0, 0, A, B, 1, 0, "R2 reserved funct3");
        run_op(enc(1, 5'd3, 5'd1, 3'b000, 5'd1), 64'd0, 4, 0, 0, A, B, 1, 0, "R2 move vs2 nonzero");
        run_op(enc(0, 5'd2, 5'd1, 3'b000, 5'd1) ^ 32'h0400_0000, 64'd0, 4, 0, 0, A, B, 1, 0, "R2 bad funct6");
        check(writes_seen == 0, "R2 no writes", 64'(writes_seen), 64'd0);
        // R10: start while busy ignored
        run_op(enc(0, 5'd2, 5'd1, 3'b000, 5'd11), 64'd0, 8, 1, 128'h33, A, B, 0, 1, "R10 start while busy");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule